// File: doc/BRIEF.md
# Forwarding Table Access Window

This block keeps an on-chip table of 68-bit forwarding entries and exposes it through a small register bus. Software never touches the table directly. To write an entry it first fills three 32-bit staging words, then writes the control register with the target index and the commit flag set. To read an entry it writes the control register with the index and the flag clear. That copies the entry into the staging words, which software then reads back. The most significant part of an entry lives in the lowest-addressed staging word.

A second port lets a search engine read and write entries directly. The bus side wins whenever both want the memory in the same cycle. A sweep sequencer zeroes the table one entry per cycle, after reset and again on software command. While it runs, a busy flag is raised and every other access to the table is held off.

The sweep sequencer has two states. SW_SWEEP zeroes the entry at its counter each cycle. SW_IDLE leaves the table to the bus and the engine. The transitions are:
- reset: enters SW_SWEEP.
- SW_SWEEP to SW_IDLE: taken on the cycle that clears the last entry.
- SW_IDLE to SW_SWEEP: taken when the clear command is written.

Top module: `tbl_access_port`

## Requirements
- R1: The staging words sit at bus word addresses 4, 5 and 6. Word 4 holds entry bits 67:64 in its bits 3:0 and reads zero above them. Word 5 holds entry bits 63:32. Word 6 holds entry bits 31:0.
- R2: A write to the control register (address 0) with bit 31 set stores the three staging words into the entry whose index is in control bits IDXF_W-1:0.
- R3: A write to the control register with bit 31 clear loads the indexed entry into the three staging words.
- R4: A commit to an index of DEPTH or more changes no entry. A fetch from such an index loads zeros into the staging words.
- R5: After reset, busy stays high for exactly DEPTH cycles. After that, every entry reads as zero, so its type field (bits 61:60) holds 0, the free code. The other type codes are 1 for address, 2 for VLAN and 3 for VLAN plus address.
- R6: Writing 1 to bit 0 of the command register (address 1) zeroes every entry, one per cycle, with busy high for DEPTH cycles. Bit 0 of that register reads back busy.
- R7: Control writes made while busy is high neither fetch nor commit, and they leave the index readback unchanged.
- R8: Bus read data appears one cycle after the address is presented. The control register reads back the most recently accepted index.
- R9: An engine request is granted in a cycle where busy is low and no bus control write is present. A granted write stores eng_wdata. A granted read returns the entry on eng_rdata with eng_rvalid one cycle later.
- R10: When a bus control write and an engine request fall in the same cycle, the engine is not granted. The engine is granted on the next cycle if that cycle is free.
- R11: An engine write to an index of DEPTH or more changes no entry. An engine read from such an index returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, registered |
| busy | output | 1 | Sweep in progress |
| eng_req | input | 1 | Engine access request |
| eng_wr | input | 1 | Engine access is a write |
| eng_idx | input | IDXF_W | Engine entry index |
| eng_wdata | input | 68 | Engine write entry |
| eng_gnt | output | 1 | Engine request accepted this cycle |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | 68 | Engine read entry |

## Verification
The bench builds the block with DEPTH = 12 and IDXF_W = 8. Because the depth is not a power of two, indices 12 to 15 are out of range while still fitting the memory's address width. Indices such as 18 and 21 go further: their low bits alias live entries, so a missing range check would overwrite an entry the bench can read back. The short depth also keeps each sweep to twelve cycles. That leaves room to fit a commit attempt, an engine request and a busy readback inside one sweep window.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    localparam int BUS_AW     = 3;
    localparam int WORD_W     = 32;
    localparam int ENTRY_W    = 68;
    localparam int HI_W       = ENTRY_W - 2 * WORD_W;
    localparam int COMMIT_BIT = 31;
    localparam int TYPE_LSB   = 60;

    localparam logic [BUS_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [BUS_AW-1:0] RA_CMD   = 3'd1;
    localparam logic [BUS_AW-1:0] RA_WORD0 = 3'd4;
    localparam logic [BUS_AW-1:0] RA_WORD1 = 3'd5;
    localparam logic [BUS_AW-1:0] RA_WORD2 = 3'd6;

    typedef enum logic [1:0] {
        ET_FREE      = 2'd0,
        ET_ADDR      = 2'd1,
        ET_VLAN      = 2'd2,
        ET_VLAN_ADDR = 2'd3
    } entry_kind_t;

    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_SWEEP = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/tbl_clear_fsm.sv
module tbl_clear_fsm
    import tbl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          clr_we,
    output logic [AW-1:0] clr_idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sweep_state_t  state_q, state_d;
    logic [AW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SW_IDLE: begin
                if (start) begin
                    state_d = SW_SWEEP;
                    cnt_d   = '0;
                end
            end
            SW_SWEEP: begin
                if (cnt_q == LAST) begin
                    state_d = SW_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q == SW_SWEEP);
        clr_we  = busy;
        clr_idx = cnt_q;
    end
endmodule

// File: rtl/tbl_store.sv
module tbl_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int W     = 68
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/tbl_stage.sv
module tbl_stage
    import tbl_pkg::*;
#(
    parameter int IDXF_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               ctrl_upd,
    input  logic               fetch_en,
    input  logic [ENTRY_W-1:0] fetch_entry,
    input  logic               busy,
    output logic [ENTRY_W-1:0] staged_entry,
    output logic [WORD_W-1:0]  rdata
);
    logic [HI_W-1:0]   w0_q;
    logic [WORD_W-1:0] w1_q, w2_q;
    logic [IDXF_W-1:0] idx_q;
    logic [WORD_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q  <= '0;
            w1_q  <= '0;
            w2_q  <= '0;
            idx_q <= '0;
        end else begin
            if (fetch_en) begin
                {w0_q, w1_q, w2_q} <= fetch_entry;
            end else if (bus_wr) begin
                case (bus_addr)
                    RA_WORD0: w0_q <= bus_wdata[HI_W-1:0];
                    RA_WORD1: w1_q <= bus_wdata;
                    RA_WORD2: w2_q <= bus_wdata;
                    default:  ;
                endcase
            end
            if (ctrl_upd) idx_q <= bus_wdata[IDXF_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CTRL:  rd_mux = WORD_W'(idx_q);
            RA_CMD:   rd_mux = WORD_W'(busy);
            RA_WORD0: rd_mux = WORD_W'(w0_q);
            RA_WORD1: rd_mux = w1_q;
            RA_WORD2: rd_mux = w2_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    assign staged_entry = {w0_q, w1_q, w2_q};
endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port
    import tbl_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int IDXF_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               busy,
    input  logic               eng_req,
    input  logic               eng_wr,
    input  logic [IDXF_W-1:0]  eng_idx,
    input  logic [67:0]        eng_wdata,
    output logic               eng_gnt,
    output logic               eng_rvalid,
    output logic [67:0]        eng_rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDXF_W-1:0] DEPTH_L = IDXF_W'(DEPTH);

    logic               bus_ctrl, ctrl_ok, bus_commit, bus_fetch, clear_start;
    logic [IDXF_W-1:0]  bus_idx;
    logic               bus_in, eng_in;
    logic               clr_we;
    logic [AW-1:0]      clr_idx;
    logic               mem_we;
    logic [AW-1:0]      mem_widx;
    logic [ENTRY_W-1:0] mem_wdata, staged, ra_data, rb_data, fetch_entry;

    assign bus_ctrl    = bus_wr && (bus_addr == RA_CTRL);
    assign ctrl_ok     = bus_ctrl && !busy;
    assign bus_commit  = ctrl_ok && bus_wdata[COMMIT_BIT];
    assign bus_fetch   = ctrl_ok && !bus_wdata[COMMIT_BIT];
    assign bus_idx     = bus_wdata[IDXF_W-1:0];
    assign bus_in      = bus_idx < DEPTH_L;
    assign eng_in      = eng_idx < DEPTH_L;
    assign clear_start = bus_wr && (bus_addr == RA_CMD) && bus_wdata[0];
    assign eng_gnt     = eng_req && !busy && !bus_ctrl;
    assign fetch_entry = bus_in ? ra_data : '0;

    tbl_clear_fsm #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (clear_start),
        .busy    (busy),
        .clr_we  (clr_we),
        .clr_idx (clr_idx)
    );

    tbl_stage #(.IDXF_W(IDXF_W)) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .ctrl_upd     (ctrl_ok),
        .fetch_en     (bus_fetch),
        .fetch_entry  (fetch_entry),
        .busy         (busy),
        .staged_entry (staged),
        .rdata        (bus_rdata)
    );

    always_comb begin
        mem_we    = 1'b0;
        mem_widx  = clr_idx;
        mem_wdata = '0;
        if (clr_we) begin
            mem_we = 1'b1;
        end else if (bus_commit && bus_in) begin
            mem_we    = 1'b1;
            mem_widx  = bus_idx[AW-1:0];
            mem_wdata = staged;
        end else if (eng_gnt && eng_wr && eng_in) begin
            mem_we    = 1'b1;
            mem_widx  = eng_idx[AW-1:0];
            mem_wdata = eng_wdata;
        end
    end

    tbl_store #(.DEPTH(DEPTH), .AW(AW), .W(ENTRY_W)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .widx    (mem_widx),
        .wdata   (mem_wdata),
        .ra_idx  (bus_idx[AW-1:0]),
        .ra_data (ra_data),
        .rb_idx  (eng_idx[AW-1:0]),
        .rb_data (rb_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_rvalid <= 1'b0;
            eng_rdata  <= '0;
        end else begin
            eng_rvalid <= eng_gnt && !eng_wr;
            if (eng_gnt && !eng_wr) eng_rdata <= eng_in ? rb_data : '0;
        end
    end
endmodule

// File: rtl/tbl_access_port_chk.sv
module tbl_access_port_chk
    import tbl_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int IDXF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              eng_req,
    input logic              eng_wr,
    input logic [IDXF_W-1:0] eng_idx,
    input logic              eng_gnt,
    input logic              eng_rvalid,
    input logic [67:0]       eng_rdata
);
    int unsigned sweep_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sweep_cnt <= 0;
        else if (busy) sweep_cnt <= sweep_cnt + 1;
        else           sweep_cnt <= 0;
    end

    assert_sweep_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sweep_cnt == DEPTH);

    assert_clear_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == RA_CMD && bus_wdata[0]) |=> busy);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !eng_gnt);

    assert_eng_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_gnt && !eng_wr) |=> eng_rvalid);

    assert_rvalid_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rvalid |-> $past(eng_gnt && !eng_wr));

    assert_bus_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && bus_wr && bus_addr == RA_CTRL) |-> !eng_gnt);

    assert_eng_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_gnt && !eng_wr && eng_idx >= IDXF_W'(DEPTH)) |=> eng_rdata == '0);
endmodule

bind tbl_access_port tbl_access_port_chk #(.DEPTH(DEPTH), .IDXF_W(IDXF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .eng_req    (eng_req),
    .eng_wr     (eng_wr),
    .eng_idx    (eng_idx),
    .eng_gnt    (eng_gnt),
    .eng_rvalid (eng_rvalid),
    .eng_rdata  (eng_rdata)
);

// File: tb/tb_tbl_access_port.sv
module tb_tbl_access_port;
    import tbl_pkg::*;

    localparam int DEPTH  = 12;
    localparam int IDXF_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              busy;
    logic              eng_req = 1'b0;
    logic              eng_wr = 1'b0;
    logic [IDXF_W-1:0] eng_idx = '0;
    logic [67:0]       eng_wdata = '0;
    logic              eng_gnt;
    logic              eng_rvalid;
    logic [67:0]       eng_rdata;

    always #5 clk = ~clk;

    tbl_access_port #(.DEPTH(DEPTH), .IDXF_W(IDXF_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .eng_req(eng_req), .eng_wr(eng_wr), .eng_idx(eng_idx),
        .eng_wdata(eng_wdata), .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid),
        .eng_rdata(eng_rdata)
    );

    typedef struct {
        int          due;
        logic [67:0] exp;
        string       req;
    } exp_t;

    exp_t bus_q[$];
    exp_t eng_q[$];
    exp_t bus_item, eng_item;
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input logic [67:0] act,
                         input logic [67:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (bus_q.size() > 0 && bus_q[0].due == cyc) begin
            bus_item = bus_q.pop_front();
            check(68'(bus_rdata) == bus_item.exp, bus_item.req, 68'(bus_rdata), bus_item.exp);
        end
        while (eng_q.size() > 0 && eng_q[0].due == cyc) begin
            eng_item = eng_q.pop_front();
            check(eng_rvalid && eng_rdata == eng_item.exp, eng_item.req, eng_rdata, eng_item.exp);
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string req);
        bus_addr = a;
        bus_wr   = 1'b0;
        bus_q.push_back('{cyc + 1, 68'(e), req});
        @(negedge clk);
    endtask

    task automatic stage_entry(input logic [67:0] e);
        bus_write(RA_WORD0, 32'(e[67:64]));
        bus_write(RA_WORD1, e[63:32]);
        bus_write(RA_WORD2, e[31:0]);
    endtask

    task automatic put_entry(input int idx, input logic [67:0] e);
        stage_entry(e);
        bus_write(RA_CTRL, 32'h8000_0000 | 32'(idx));
    endtask

    task automatic expect_entry(input int idx, input logic [67:0] e, input string req);
        bus_write(RA_CTRL, 32'(idx));
        bus_read(RA_WORD0, 32'(e[67:64]), req);
        bus_read(RA_WORD1, e[63:32], req);
        bus_read(RA_WORD2, e[31:0], req);
    endtask

    task automatic eng_op(input bit wr, input int idx, input logic [67:0] d,
                          input logic [67:0] e, input string req);
        eng_req   = 1'b1;
        eng_wr    = wr;
        eng_idx   = IDXF_W'(idx);
        eng_wdata = d;
        #1;
        while (!eng_gnt) begin
            @(negedge clk);
            #1;
        end
        if (!wr) eng_q.push_back('{cyc + 1, e, req});
        @(negedge clk);
        eng_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [67:0] e1, e2, e3;

    initial begin
        // type codes in bits 61:60: e1 address, e2 VLAN, e3 VLAN plus address
        e1 = 68'h9_1234_5678_9ABC_DEF0;
        e2 = 68'h3_A000_0001_0000_0042;
        e3 = 68'h6_3000_00FF_FFFF_FFFF;
        check(e1[61:60] == ET_ADDR && e2[61:60] == ET_VLAN && e3[61:60] == ET_VLAN_ADDR,
              "R5 type codes", 68'(e1[61:60]), 68'(ET_ADDR));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        begin
            int n = 0;
            while (busy) begin
                n++;
                @(negedge clk);
            end
            check(n == DEPTH, "R5 reset sweep length", 68'(n), 68'(DEPTH));
        end
        bus_read(RA_CMD, 32'd0, "R6 busy readback idle");
        bus_read(RA_CTRL, 32'd0, "R8 control reset value");
        expect_entry(0, '0, "R5 entry free after reset");
        expect_entry(DEPTH - 1, '0, "R5 last entry free after reset");

        bus_write(RA_WORD0, 32'hFFFF_FFFA);
        bus_read(RA_WORD0, 32'h0000_000A, "R1 top word width");
        bus_write(RA_WORD1, 32'hCAFE_0001);
        bus_read(RA_WORD1, 32'hCAFE_0001, "R1 middle word");
        bus_write(RA_WORD2, 32'h0BAD_F00D);
        bus_read(RA_WORD2, 32'h0BAD_F00D, "R1 low word");

        put_entry(2, e1);
        put_entry(DEPTH - 1, e2);
        put_entry(5, e3);
        expect_entry(2, e1, "R2 R3 commit and fetch idx 2");
        expect_entry(DEPTH - 1, e2, "R2 R3 commit and fetch last idx");
        expect_entry(5, e3, "R2 R3 commit and fetch idx 5");
        bus_read(RA_CTRL, 32'd5, "R8 control index readback");

        put_entry(16 + 2, e3);
        expect_entry(2, e1, "R4 out of range commit ignored");
        expect_entry(16 + 2, '0, "R4 out of range fetch zeros");

        eng_op(1'b0, 2, '0, e1, "R9 engine read");
        eng_op(1'b1, 7, e2, '0, "R9 engine write");
        expect_entry(7, e2, "R9 engine write seen on bus");
        eng_op(1'b0, 7, '0, e2, "R9 engine read back");

        eng_op(1'b1, 16 + 5, e1, '0, "R11 engine out of range write");
        eng_op(1'b0, 5, '0, e3, "R11 entry unchanged");
        eng_op(1'b0, 16 + 5, '0, '0, "R11 engine out of range read zeros");

        // R10: bus commit and engine write collide
        stage_entry(e1);
        bus_addr  = RA_CTRL;
        bus_wdata = 32'h8000_0008;
        bus_wr    = 1'b1;
        eng_req   = 1'b1;
        eng_wr    = 1'b1;
        eng_idx   = IDXF_W'(9);
        eng_wdata = e3;
        #1;
        check(eng_gnt == 1'b0, "R10 engine waits for bus", 68'(eng_gnt), 68'd0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check(eng_gnt == 1'b1, "R10 engine granted next cycle", 68'(eng_gnt), 68'd1);
        @(negedge clk);
        eng_req = 1'b0;
        expect_entry(8, e1, "R10 bus commit landed");
        expect_entry(9, e3, "R10 engine write landed");

        // R6 R7: clear, with a commit and an engine request inside the sweep
        bus_write(RA_CMD, 32'd1);
        bus_read(RA_CMD, 32'd1, "R6 busy readback during sweep");
        stage_entry(e2);
        bus_write(RA_CTRL, 32'h8000_0000);
        eng_req = 1'b1;
        eng_wr  = 1'b0;
        eng_idx = '0;
        #1;
        check(eng_gnt == 1'b0, "R9 no grant while busy", 68'(eng_gnt), 68'd0);
        @(negedge clk);
        eng_req = 1'b0;
        while (busy) @(negedge clk);
        bus_read(RA_CTRL, 32'd9, "R7 index unchanged by busy write");
        expect_entry(0, '0, "R7 commit during sweep ignored");
        expect_entry(2, '0, "R6 clear zeroes idx 2");
        expect_entry(9, '0, "R6 clear zeroes idx 9");
        expect_entry(DEPTH - 1, '0, "R6 clear zeroes last idx");

        repeat (3) @(negedge clk);
        check(bus_q.size() == 0 && eng_q.size() == 0, "R8 R9 all results seen",
              68'(bus_q.size() + eng_q.size()), 68'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule